// File: doc/BRIEF.md
# Timed Per-Pin Waveform Scheduler

This block plays back a small table of timed operations onto a set of material-facing pins. Each table entry names one pin, what to do on it (hold it idle to let the material settle, drive a static level, drive a square wave, or open a sampling window) and the window in milliseconds during which that happens. The host fills the table through a write port and then pulses a start input. A millisecond timebase then runs, and every pin follows its own track at the same time as all the others.

Each pin has its own lane. The lane looks at every table entry, picks the winning active entry for its pin, and produces a level code, a drive enable and a sample gate. Any pin can therefore be a driven input in one run and a sampled output in the next, with no change in wiring. When the time counter reaches the latest end time in the table, playback stops and a done flag is raised.

Top module: `pin_track_sched`

## Requirements
- R1: An entry is stored at `wr_addr_i` when `wr_en_i` is high. `wr_data_i` is laid out as [48:46] pin index, [45:44] kind, [43:40] square shift, [39:32] amplitude, [31:16] start ms, [15:0] end ms. The kind codes are 00 idle, 01 static, 10 square and 11 sample.
- R2: A `start_i` pulse sets `time_ms_o` to 0, raises `running_o` and clears `done_o` on the next edge. The time then goes up by 1 every `TICK_DIV` clocks.
- R3: An entry is active while running and start <= time < end.
- R4: An active static entry drives its pin's level to the amplitude and raises the drive enable.
- R5: An active square entry drives the amplitude while bit `shift` of (time - start) is 0 and drives code 0 while it is 1. The drive enable stays high in both phases.
- R6: An active sample entry raises the pin's sample gate only inside its window. The drive enable stays low and the level is code 128.
- R7: An active idle entry holds the pin at code 128 with drive and sample low, and it hides any higher-index entry on that pin.
- R8: When several active entries target one pin, the one with the lowest table index wins.
- R9: A pin with no active entry, and every pin while not running, shows level 128 with drive and sample low.
- R10: When the time reaches the largest end time in the table, `done_o` rises, `running_o` falls and the time holds until the next start.
- R11: The 16-bit time counter stops at 65535 and does not wrap.
- R12: After reset the time is 0, running and done are low, and all pins are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | 4 | Table entry index |
| wr_data_i | input | 49 | Packed entry (see R1) |
| start_i | input | 1 | Start playback pulse |
| time_ms_o | output | 16 | Playback time in ms |
| running_o | output | 1 | Playback in progress |
| done_o | output | 1 | Playback finished |
| pin_level_o | output | 64 | 8-bit level code per pin, pin p at [8p+7:8p] |
| pin_drive_o | output | 8 | Per-pin drive enable |
| pin_sample_o | output | 8 | Per-pin sample gate |

## Verification
The main table puts several tracks side by side. One pin has a static level that an idle settle entry interrupts, so the check can tell priority from window edges. Another pin has two overlapping static entries, which separates lowest-index-wins from last-written-wins. A square wave is checked across both of its phases, and a sample window is checked on both sides of its edges. Further directed runs cover reset, a restart after done and the tick rate, and a table whose end time is 65535, which shows the counter stopping without wrapping.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int PIN_W   = 3;
  localparam int TIME_W  = 16;
  localparam int AMP_W   = 8;
  localparam int SHIFT_W = 4;
  localparam logic [AMP_W-1:0] MID_CODE = AMP_W'(1 << (AMP_W - 1));

  typedef enum logic [1:0] {
    K_IDLE   = 2'b00,
    K_STATIC = 2'b01,
    K_SQUARE = 2'b10,
    K_SAMPLE = 2'b11
  } kind_e;

  typedef struct packed {
    logic [PIN_W-1:0]   pin;
    kind_e              kind;
    logic [SHIFT_W-1:0] shift;
    logic [AMP_W-1:0]   amp;
    logic [TIME_W-1:0]  t_start;
    logic [TIME_W-1:0]  t_end;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);
endpackage

// File: rtl/sched_timebase.sv
module sched_timebase
  import sched_pkg::*;
#(
  parameter int TICK_DIV = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TIME_W-1:0] max_end_i,
  output logic [TIME_W-1:0] time_o,
  output logic              run_o,
  output logic              done_o
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0]  pre_q;
  logic [TIME_W-1:0] time_q;
  logic              run_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      time_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      pre_q  <= '0;
      time_q <= '0;
      run_q  <= 1'b1;
      done_q <= 1'b0;
    end else if (run_q) begin
      if (time_q >= max_end_i) begin
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        if (time_q != '1) time_q <= time_q + 1'b1;  // saturate
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign time_o = time_q;
  assign run_o  = run_q;
  assign done_o = done_q;

  p_start_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (run_q && !done_q && time_q == '0));
  p_step_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !start_i) |=> (time_q - $past(time_q) <= TIME_W'(1)));
  p_sat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (time_q == '1 && !start_i) |=> time_q == '1);
  p_done_stops_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> (!run_q && $stable(time_q)));
endmodule

// File: rtl/sched_table.sv
module sched_table
  import sched_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [$clog2(N_ENTRIES)-1:0] wr_addr_i,
  input  entry_t                       wr_data_i,
  output entry_t                       tbl_o [N_ENTRIES],
  output logic [TIME_W-1:0]            max_end_o
);
  entry_t tbl_q [N_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_ENTRIES; e++) tbl_q[e] <= '0;
    end else if (wr_en_i) begin
      tbl_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_comb begin
    max_end_o = '0;
    for (int e = 0; e < N_ENTRIES; e++)
      if (tbl_q[e].t_end > max_end_o) max_end_o = tbl_q[e].t_end;
  end

  assign tbl_o = tbl_q;
endmodule

// File: rtl/sched_pin_lane.sv
module sched_pin_lane
  import sched_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PIN_IDX   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  entry_t            tbl_i [N_ENTRIES],
  input  logic [TIME_W-1:0] time_i,
  input  logic              run_i,
  output logic [AMP_W-1:0]  level_o,
  output logic              drive_o,
  output logic              sample_o
);
  logic              hit;
  entry_t            sel;
  logic [TIME_W-1:0] rel;

  // scan from the top so the lowest active index is assigned last
  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int e = N_ENTRIES - 1; e >= 0; e--) begin
      if (run_i && tbl_i[e].pin == PIN_W'(PIN_IDX) &&
          time_i >= tbl_i[e].t_start && time_i < tbl_i[e].t_end) begin
        hit = 1'b1;
        sel = tbl_i[e];
      end
    end
  end

  assign rel = time_i - sel.t_start;

  always_comb begin
    level_o  = MID_CODE;
    drive_o  = 1'b0;
    sample_o = 1'b0;
    if (hit) begin
      unique case (sel.kind)
        K_STATIC: begin
          level_o = sel.amp;
          drive_o = 1'b1;
        end
        K_SQUARE: begin
          level_o = rel[sel.shift] ? '0 : sel.amp;
          drive_o = 1'b1;
        end
        K_SAMPLE: sample_o = 1'b1;
        default: ;  // idle: settle slot
      endcase
    end
  end

  p_role_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_o && sample_o));
  p_undriven_mid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> level_o == MID_CODE);
  p_quiet_stopped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!drive_o && !sample_o));
endmodule

// File: rtl/pin_track_sched.sv
module pin_track_sched
  import sched_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int TICK_DIV  = 50000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [$clog2(N_ENTRIES)-1:0] wr_addr_i,
  input  logic [48:0]                  wr_data_i,
  input  logic                         start_i,
  output logic [15:0]                  time_ms_o,
  output logic                         running_o,
  output logic                         done_o,
  output logic [63:0]                  pin_level_o,
  output logic [7:0]                   pin_drive_o,
  output logic [7:0]                   pin_sample_o
);
  localparam int N_PINS = 1 << PIN_W;

  entry_t            tbl [N_ENTRIES];
  logic [TIME_W-1:0] max_end;
  logic [TIME_W-1:0] now;
  logic              run;

  sched_table #(.N_ENTRIES(N_ENTRIES)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (entry_t'(wr_data_i)),
    .tbl_o     (tbl),
    .max_end_o (max_end)
  );

  sched_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .max_end_i (max_end),
    .time_o    (now),
    .run_o     (run),
    .done_o    (done_o)
  );

  for (genvar p = 0; p < N_PINS; p++) begin : g_lane
    sched_pin_lane #(.N_ENTRIES(N_ENTRIES), .PIN_IDX(p)) u_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tbl_i    (tbl),
      .time_i   (now),
      .run_i    (run),
      .level_o  (pin_level_o[p*AMP_W +: AMP_W]),
      .drive_o  (pin_drive_o[p]),
      .sample_o (pin_sample_o[p])
    );
  end

  assign time_ms_o = now;
  assign running_o = run;
endmodule

// File: tb/tb_pin_track_sched.sv
module tb_pin_track_sched;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [48:0] wr_data_i = '0;
  logic        start_i = 1'b0;
  logic [15:0] time_ms_o;
  logic        running_o, done_o;
  logic [63:0] pin_level_o;
  logic [7:0]  pin_drive_o, pin_sample_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pin_track_sched #(.N_ENTRIES(16), .TICK_DIV(2)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .start_i(start_i), .time_ms_o(time_ms_o),
    .running_o(running_o), .done_o(done_o), .pin_level_o(pin_level_o),
    .pin_drive_o(pin_drive_o), .pin_sample_o(pin_sample_o)
  );

  // {time, pin, level, drive, sample, requirement number}
  typedef struct packed {
    logic [15:0] t;
    logic [2:0]  pin;
    logic [7:0]  lvl;
    logic        drv;
    logic        smp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{16'd0,  3'd1, 8'd200, 1'b1, 1'b0, 8'd4},   // R4 static
    '{16'd0,  3'd3, 8'd99,  1'b1, 1'b0, 8'd8},   // R8 only e5 active
    '{16'd0,  3'd0, 8'd128, 1'b0, 1'b0, 8'd9},   // R9 not yet active
    '{16'd0,  3'd2, 8'd128, 1'b0, 1'b0, 8'd3},   // R3 before start
    '{16'd2,  3'd1, 8'd128, 1'b0, 1'b0, 8'd7},   // R7 settle hides e1
    '{16'd3,  3'd2, 8'd240, 1'b1, 1'b0, 8'd5},   // R5 high phase
    '{16'd4,  3'd3, 8'd50,  1'b1, 1'b0, 8'd8},   // R8 lower index wins
    '{16'd4,  3'd1, 8'd128, 1'b0, 1'b0, 8'd7},   // R7
    '{16'd5,  3'd2, 8'd0,   1'b1, 1'b0, 8'd5},   // R5 low phase
    '{16'd5,  3'd1, 8'd200, 1'b1, 1'b0, 8'd3},   // R3 end exclusive
    '{16'd5,  3'd0, 8'd128, 1'b0, 1'b0, 8'd6},   // R6 before window
    '{16'd6,  3'd0, 8'd128, 1'b0, 1'b1, 8'd6},   // R6 window open
    '{16'd6,  3'd2, 8'd0,   1'b1, 1'b0, 8'd5},   // R5
    '{16'd7,  3'd2, 8'd240, 1'b1, 1'b0, 8'd5},   // R5 back high
    '{16'd7,  3'd3, 8'd50,  1'b1, 1'b0, 8'd8},   // R8
    '{16'd8,  3'd3, 8'd99,  1'b1, 1'b0, 8'd8},   // R8 e4 ended
    '{16'd8,  3'd0, 8'd128, 1'b0, 1'b1, 8'd6},   // R6
    '{16'd9,  3'd0, 8'd128, 1'b0, 1'b0, 8'd6},   // R6 window closed
    '{16'd9,  3'd2, 8'd0,   1'b1, 1'b0, 8'd5},   // R5
    '{16'd10, 3'd1, 8'd128, 1'b0, 1'b0, 8'd9},   // R9 track over
    '{16'd10, 3'd6, 8'd128, 1'b0, 1'b0, 8'd9},   // R9 unused pin
    '{16'd11, 3'd3, 8'd99,  1'b1, 1'b0, 8'd4},   // R4
    '{16'd11, 3'd2, 8'd128, 1'b0, 1'b0, 8'd3},   // R3 square ended
    '{16'd12, 3'd3, 8'd128, 1'b0, 1'b0, 8'd10}   // R10 stopped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input int a, input logic [2:0] pin, input logic [1:0] kind,
                     input logic [3:0] sh, input logic [7:0] amp,
                     input logic [15:0] st, input logic [15:0] en);
    @(negedge clk);
    wr_en_i   = 1'b1;
    wr_addr_i = 4'(a);
    wr_data_i = {pin, kind, sh, amp, st, en};
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 time", 32'(time_ms_o), 0);
    chk("R12 run/done", {running_o, done_o}, 0);
    chk("R12 levels", 32'(pin_level_o[31:0]), 32'h80808080);
    chk("R12 drive/sample", {pin_drive_o, pin_sample_o}, 0);

    // R1 loading: pin, kind (00 idle 01 static 10 square 11 sample), shift, amp, start, end
    put(0, 3'd1, 2'b00, 4'd0, 8'd0,   16'd2, 16'd5);
    put(1, 3'd1, 2'b01, 4'd0, 8'd200, 16'd0, 16'd10);
    put(2, 3'd0, 2'b11, 4'd0, 8'd0,   16'd6, 16'd9);
    put(3, 3'd2, 2'b10, 4'd1, 8'd240, 16'd3, 16'd11);
    put(4, 3'd3, 2'b01, 4'd0, 8'd50,  16'd4, 16'd8);
    put(5, 3'd3, 2'b01, 4'd0, 8'd99,  16'd0, 16'd12);
    chk("R9 loaded but idle", {24'(pin_drive_o), pin_sample_o}, 0);

    kick();
    chk("R2 start", {15'd0, running_o, done_o, time_ms_o}, {15'd0, 1'b1, 1'b0, 16'd0});
    for (int i = 0; i < NV; i++) begin
      while (time_ms_o < VEC[i].t) @(negedge clk);
      chk($sformatf("R%0d t=%0d pin%0d", VEC[i].req, VEC[i].t, VEC[i].pin),
          {pin_level_o[VEC[i].pin*8 +: 8], pin_drive_o[VEC[i].pin], pin_sample_o[VEC[i].pin]},
          {VEC[i].lvl, VEC[i].drv, VEC[i].smp});
    end
    repeat (2) @(negedge clk);
    chk("R10 done", {done_o, running_o, time_ms_o}, {1'b1, 1'b0, 16'd12});
    repeat (6) @(negedge clk);
    chk("R10 holds", 32'(time_ms_o), 12);

    // R2 restart and tick rate
    kick();
    chk("R2 restart", {done_o, running_o, time_ms_o}, {1'b0, 1'b1, 16'd0});
    repeat (10) @(negedge clk);
    chk("R2 rate", 32'(time_ms_o), 5);

    // R11 saturation at 65535
    put(15, 3'd7, 2'b01, 4'd0, 8'd255, 16'd0, 16'hFFFF);
    kick();
    @(negedge clk);
    chk("R4 pin7 static", {pin_level_o[63:56], pin_drive_o[7]}, {8'd255, 1'b1});
    while (!done_o) @(negedge clk);
    chk("R11 top", 32'(time_ms_o), 32'hFFFF);
    repeat (8) @(negedge clk);
    chk("R11 no wrap", 32'(time_ms_o), 32'hFFFF);
    chk("R9 after done", {pin_drive_o, pin_sample_o}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule